// File: doc/BRIEF.md
# Vector Issue Pipelines

This block is the issue and timing shell of a vector arithmetic unit. One issue port accepts at most one instruction per cycle. Each instruction carries a 2-bit class, a destination tag and a payload. The class selects one of four subunits: a simple integer/logical pipe of depth 1, a complex integer pipe of depth 3, a floating-point pipe of depth 4, or a single-cycle permute unit. Each pipe takes a new instruction every cycle and runs on its own once the instruction has entered. The arithmetic is not modelled: the payload passes through unchanged and comes out with the tag.

A second input dispatches a permute operation straight to the permute unit, in the same cycle as an arithmetic issue. Every subunit has its own result port. Results therefore come back out of issue order, and up to four can appear in the same cycle.

A stall input holds issue back while the pipes keep draining. A flush input cancels all work in flight.

Top module: `vissue_top`

## Requirements
- R1: While reset is asserted, and once it has been released, all four result valids are low. The issue-ready output is low during reset and goes high within three cycles of reset release when neither stall nor flush is active.
- R2: An issue accepted with class 0 (`iss_valid` and `iss_ready` both high at a rising edge) appears on the simple result port, with its tag and data unchanged, in the cycle after the accepting edge.
- R3: An accepted issue with class 1 appears on the complex result port, with its tag and data, three cycles after the accepting edge.
- R4: An accepted issue with class 2 appears on the floating-point result port, with its tag and data, four cycles after the accepting edge.
- R5: Each subunit accepts a new instruction on every cycle. A run of back-to-back issues to one class returns on consecutive cycles, in issue order.
- R6: The subunits run independently. Issues made on different cycles to subunits of different depth can return out of order or in the same cycle, each on its own port.
- R7: Class 3 and the separate permute input (`pm_valid`) both feed the permute result port one cycle later. The separate input has priority: while `pm_valid` is high, `iss_ready` is low whenever `iss_class` is 3.
- R8: While `stall` is high, `iss_ready` is low and no issue is accepted. Instructions already in flight, and the separate permute input, still complete on time.
- R9: While `flush` is high, `iss_ready` is low and the permute input is ignored. At the next edge every in-flight instruction in all subunits is cancelled, so no result valid is high in the following cycle.
- R10: A cycle with `iss_valid` low produces no result on any arithmetic port, whatever the class, tag and data inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| iss_valid | input | 1 | Issue request |
| iss_ready | output | 1 | Issue can be taken this cycle |
| iss_class | input | 2 | Subunit class: 0 simple, 1 complex, 2 floating-point, 3 permute |
| iss_tag | input | TAG_W | Destination tag of the issued instruction |
| iss_data | input | DATA_W | Pass-through payload |
| stall | input | 1 | Hold back new issues |
| flush | input | 1 | Cancel all in-flight instructions |
| pm_valid | input | 1 | Separate permute dispatch |
| pm_tag | input | TAG_W | Tag of the separate permute dispatch |
| pm_data | input | DATA_W | Payload of the separate permute dispatch |
| res_si_valid | output | 1 | Simple result valid |
| res_si_tag | output | TAG_W | Simple result tag |
| res_si_data | output | DATA_W | Simple result payload |
| res_ci_valid | output | 1 | Complex result valid |
| res_ci_tag | output | TAG_W | Complex result tag |
| res_ci_data | output | DATA_W | Complex result payload |
| res_fp_valid | output | 1 | Floating-point result valid |
| res_fp_tag | output | TAG_W | Floating-point result tag |
| res_fp_data | output | DATA_W | Floating-point result payload |
| res_pm_valid | output | 1 | Permute result valid |
| res_pm_tag | output | TAG_W | Permute result tag |
| res_pm_data | output | DATA_W | Permute result payload |

## Verification
The bench goes after cycles where results collide. A floating-point, a complex, a simple and a side permute issue are staged so that all four land in one cycle; a design that shared one result path or serialised the pipes would drop or delay one of them. A class-3 issue is made while the side permute input is busy; a design without the priority rule would lose an operation or merge two. A flush is aimed at work in every stage; a pipe that failed to clear a stage would leak a stale result after the flush. A long pseudo-random sweep over valid, class, stall, flush and permute combinations checks every port on every cycle against latencies computed in the bench. This catches an off-by-one depth and an issue that is accepted under stall.

// File: rtl/vissue_pkg.sv
package vissue_pkg;

  typedef enum logic [1:0] {
    CLS_SIMPLE = 2'd0,
    CLS_CPLX   = 2'd1,
    CLS_FLT    = 2'd2,
    CLS_PERM   = 2'd3
  } vclass_e;

  localparam int NUM_UNITS = 4;
  localparam int UNIT_SI   = 0;
  localparam int UNIT_CI   = 1;
  localparam int UNIT_FP   = 2;
  localparam int UNIT_PM   = 3;

endpackage

// File: rtl/vissue_rst_sync.sv
module vissue_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/vissue_route.sv
module vissue_route
  import vissue_pkg::*;
(
  input  logic                 live,
  input  logic                 iss_valid,
  input  logic [1:0]           iss_class,
  input  logic                 stall,
  input  logic                 flush,
  input  logic                 pm_valid,
  output logic                 iss_ready,
  output logic                 side_sel,
  output logic [NUM_UNITS-1:0] unit_go
);

  logic conflict;
  logic accept;
  logic side_go;

  always_comb begin
    conflict  = (iss_class == CLS_PERM) && pm_valid;
    iss_ready = live && !stall && !flush && !conflict;
    accept    = iss_valid && iss_ready;
    side_go   = live && pm_valid && !flush;
    side_sel  = pm_valid;
  end

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_go
    if (u == UNIT_PM) begin : g_pm
      assign unit_go[u] = side_go || (accept && (iss_class == CLS_PERM));
    end else begin : g_arith
      assign unit_go[u] = accept && (iss_class == 2'(u));
    end
  end

endmodule

// File: rtl/vissue_pipe.sv
module vissue_pipe #(
  parameter int DEPTH = 3,
  parameter int W     = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         in_v,
  input  logic [W-1:0] in_pay,
  output logic         out_v,
  output logic [W-1:0] out_pay
);

  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] vld_d;
  logic [W-1:0]     pay_q [DEPTH];

  always_comb begin
    vld_d[0] = in_v && !flush;
    for (int i = 1; i < DEPTH; i++) begin
      vld_d[i] = vld_q[i-1] && !flush;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (in_v) pay_q[0] <= in_pay;
    for (int i = 1; i < DEPTH; i++) begin
      if (vld_q[i-1]) pay_q[i] <= pay_q[i-1];
    end
  end

  assign out_v   = vld_q[DEPTH-1];
  assign out_pay = pay_q[DEPTH-1];

endmodule

// File: rtl/vissue_top.sv
module vissue_top
  import vissue_pkg::*;
#(
  parameter int TAG_W  = 4,
  parameter int DATA_W = 8,
  parameter int LAT_SI = 1,
  parameter int LAT_CI = 3,
  parameter int LAT_FP = 4,
  parameter int LAT_PM = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  output logic              iss_ready,
  input  logic [1:0]        iss_class,
  input  logic [TAG_W-1:0]  iss_tag,
  input  logic [DATA_W-1:0] iss_data,
  input  logic              stall,
  input  logic              flush,
  input  logic              pm_valid,
  input  logic [TAG_W-1:0]  pm_tag,
  input  logic [DATA_W-1:0] pm_data,
  output logic              res_si_valid,
  output logic [TAG_W-1:0]  res_si_tag,
  output logic [DATA_W-1:0] res_si_data,
  output logic              res_ci_valid,
  output logic [TAG_W-1:0]  res_ci_tag,
  output logic [DATA_W-1:0] res_ci_data,
  output logic              res_fp_valid,
  output logic [TAG_W-1:0]  res_fp_tag,
  output logic [DATA_W-1:0] res_fp_data,
  output logic              res_pm_valid,
  output logic [TAG_W-1:0]  res_pm_tag,
  output logic [DATA_W-1:0] res_pm_data
);

  localparam int PAY_W = TAG_W + DATA_W;

  logic                 srst_n;
  logic                 side_sel;
  logic [NUM_UNITS-1:0] unit_go;
  logic [NUM_UNITS-1:0] unit_ov;
  logic [PAY_W-1:0]     unit_pay [NUM_UNITS];
  logic [PAY_W-1:0]     unit_op  [NUM_UNITS];

  vissue_rst_sync #(.STAGES(2)) rst_i (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  vissue_route route_i (
    .live      (srst_n),
    .iss_valid (iss_valid),
    .iss_class (iss_class),
    .stall     (stall),
    .flush     (flush),
    .pm_valid  (pm_valid),
    .iss_ready (iss_ready),
    .side_sel  (side_sel),
    .unit_go   (unit_go)
  );

  always_comb begin
    for (int u = 0; u < NUM_UNITS; u++) begin
      unit_pay[u] = {iss_tag, iss_data};
    end
    if (side_sel) unit_pay[UNIT_PM] = {pm_tag, pm_data};
  end

  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
    localparam int L = (g == UNIT_SI) ? LAT_SI :
                       (g == UNIT_CI) ? LAT_CI :
                       (g == UNIT_FP) ? LAT_FP : LAT_PM;
    vissue_pipe #(.DEPTH(L), .W(PAY_W)) pipe_i (
      .clk     (clk),
      .rst_n   (srst_n),
      .flush   (flush),
      .in_v    (unit_go[g]),
      .in_pay  (unit_pay[g]),
      .out_v   (unit_ov[g]),
      .out_pay (unit_op[g])
    );
  end

  assign res_si_valid              = unit_ov[UNIT_SI];
  assign {res_si_tag, res_si_data} = unit_op[UNIT_SI];
  assign res_ci_valid              = unit_ov[UNIT_CI];
  assign {res_ci_tag, res_ci_data} = unit_op[UNIT_CI];
  assign res_fp_valid              = unit_ov[UNIT_FP];
  assign {res_fp_tag, res_fp_data} = unit_op[UNIT_FP];
  assign res_pm_valid              = unit_ov[UNIT_PM];
  assign {res_pm_tag, res_pm_data} = unit_op[UNIT_PM];

endmodule

// File: rtl/vissue_chk.sv
module vissue_chk #(
  parameter int TAG_W  = 4,
  parameter int DATA_W = 8,
  parameter int LAT_CI = 3,
  parameter int LAT_FP = 4
) (
  input logic              clk,
  input logic              srst_n,
  input logic              iss_valid,
  input logic              iss_ready,
  input logic [1:0]        iss_class,
  input logic [TAG_W-1:0]  iss_tag,
  input logic [DATA_W-1:0] iss_data,
  input logic              stall,
  input logic              flush,
  input logic              pm_valid,
  input logic [TAG_W-1:0]  pm_tag,
  input logic [DATA_W-1:0] pm_data,
  input logic              res_si_valid,
  input logic [TAG_W-1:0]  res_si_tag,
  input logic [DATA_W-1:0] res_si_data,
  input logic              res_ci_valid,
  input logic [TAG_W-1:0]  res_ci_tag,
  input logic [DATA_W-1:0] res_ci_data,
  input logic              res_fp_valid,
  input logic [TAG_W-1:0]  res_fp_tag,
  input logic [DATA_W-1:0] res_fp_data,
  input logic              res_pm_valid,
  input logic [TAG_W-1:0]  res_pm_tag,
  input logic [DATA_W-1:0] res_pm_data
);

  logic acc;
  logic acc_si, acc_ci, acc_fp;
  assign acc    = iss_valid && iss_ready;
  assign acc_si = acc && (iss_class == 2'd0);
  assign acc_ci = acc && (iss_class == 2'd1);
  assign acc_fp = acc && (iss_class == 2'd2);

  p_simple_lat_r2: assert property (@(posedge clk) disable iff (!srst_n)
    acc_si |=> res_si_valid && res_si_tag == $past(iss_tag) && res_si_data == $past(iss_data));

  p_cplx_src_r3: assert property (@(posedge clk) disable iff (!srst_n)
    res_ci_valid |-> $past(acc_ci, LAT_CI) && res_ci_tag == $past(iss_tag, LAT_CI)
                     && res_ci_data == $past(iss_data, LAT_CI));

  p_flt_src_r4: assert property (@(posedge clk) disable iff (!srst_n)
    res_fp_valid |-> $past(acc_fp, LAT_FP) && res_fp_tag == $past(iss_tag, LAT_FP)
                     && res_fp_data == $past(iss_data, LAT_FP));

  p_side_perm_r7: assert property (@(posedge clk) disable iff (!srst_n)
    pm_valid && !flush |=> res_pm_valid && res_pm_tag == $past(pm_tag) && res_pm_data == $past(pm_data));

  p_perm_prio_r7: assert property (@(posedge clk) disable iff (!srst_n)
    pm_valid && iss_class == 2'd3 |-> !iss_ready);

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!srst_n)
    stall |-> !iss_ready);

  p_flush_clear_r9: assert property (@(posedge clk) disable iff (!srst_n)
    flush |=> !res_si_valid && !res_ci_valid && !res_fp_valid && !res_pm_valid);

  p_simple_src_r10: assert property (@(posedge clk) disable iff (!srst_n)
    res_si_valid |-> $past(acc_si));

endmodule

bind vissue_top vissue_chk #(
  .TAG_W  (TAG_W),
  .DATA_W (DATA_W),
  .LAT_CI (LAT_CI),
  .LAT_FP (LAT_FP)
) chk_i (.*);

// File: tb/vissue_top_tb_top.sv
`timescale 1ns/1ps
module vissue_top_tb_top;

  localparam int TW = 4;
  localparam int DW = 8;
  localparam int PW = TW + DW;
  localparam int LAT [4] = '{1, 3, 4, 1};

  logic          clk = 1'b0;
  logic          rst_n;
  logic          iss_valid, iss_ready;
  logic [1:0]    iss_class;
  logic [TW-1:0] iss_tag, pm_tag;
  logic [DW-1:0] iss_data, pm_data;
  logic          stall, flush, pm_valid;
  logic          rv [4];
  logic [TW-1:0] rt [4];
  logic [DW-1:0] rd [4];

  int total = 0;
  int bad = 0;
  bit done = 0;
  int n = 0;
  string phase = "R1";

  bit            ev [4][8];
  logic [PW-1:0] ep [4][8];

  always #10 clk = ~clk;

  vissue_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_class(iss_class),
    .iss_tag(iss_tag), .iss_data(iss_data),
    .stall(stall), .flush(flush),
    .pm_valid(pm_valid), .pm_tag(pm_tag), .pm_data(pm_data),
    .res_si_valid(rv[0]), .res_si_tag(rt[0]), .res_si_data(rd[0]),
    .res_ci_valid(rv[1]), .res_ci_tag(rt[1]), .res_ci_data(rd[1]),
    .res_fp_valid(rv[2]), .res_fp_tag(rt[2]), .res_fp_data(rd[2]),
    .res_pm_valid(rv[3]), .res_pm_tag(rt[3]), .res_pm_data(rd[3])
  );

  function automatic string unit_req(int u);
    case (u)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R7";
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [PW-1:0] act, logic [PW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s (%s) step=%0d act=%h exp=%h", req, phase, n, act, exp);
    end
  endtask

  task automatic step(bit v, logic [1:0] c, bit st, bit fl, bit pv);
    bit exp_ready, acc;
    int s;
    @(negedge clk);
    s = n % 8;
    for (int u = 0; u < 4; u++) begin
      check(rv[u] == ev[u][s], unit_req(u), PW'(rv[u]), PW'(ev[u][s]));
      if (ev[u][s]) check({rt[u], rd[u]} == ep[u][s], unit_req(u), {rt[u], rd[u]}, ep[u][s]);
      ev[u][s] = 1'b0;
    end
    iss_valid = v; iss_class = c; stall = st; flush = fl; pm_valid = pv;
    iss_tag  = TW'(n);
    iss_data = DW'(n * 29 + 5);
    pm_tag   = ~TW'(n);
    pm_data  = DW'(n * 13 + 1);
    #1;
    exp_ready = !st && !fl && !(c == 2'd3 && pv);
    check(iss_ready == exp_ready, "R8 R9 R7 ready", PW'(iss_ready), PW'(exp_ready));
    acc = v && exp_ready;
    if (fl) for (int k = 1; k <= 4; k++) for (int u = 0; u < 4; u++) ev[u][(n + k) % 8] = 1'b0;
    if (acc) begin
      ev[c][(n + LAT[c]) % 8] = 1'b1;
      ep[c][(n + LAT[c]) % 8] = {iss_tag, iss_data};
    end
    if (pv && !fl) begin
      ev[3][(n + 1) % 8] = 1'b1;
      ep[3][(n + 1) % 8] = {pm_tag, pm_data};
    end
    n++;
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) step(1'b0, 2'(i), 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    rst_n = 1'b0; iss_valid = 0; iss_class = 0; iss_tag = 0; iss_data = 0;
    stall = 0; flush = 0; pm_valid = 0; pm_tag = 0; pm_data = 0;
    for (int u = 0; u < 4; u++) for (int s = 0; s < 8; s++) begin ev[u][s] = 0; ep[u][s] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int u = 0; u < 4; u++) check(rv[u] == 1'b0, "R1", PW'(rv[u]), '0);
    check(iss_ready == 1'b0, "R1", PW'(iss_ready), '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(iss_ready == 1'b1, "R1", PW'(iss_ready), PW'(1));
    for (int u = 0; u < 4; u++) check(rv[u] == 1'b0, "R1", PW'(rv[u]), '0);

    phase = "R2";  step(1, 2'd0, 0, 0, 0); idle(5);
    phase = "R3";  step(1, 2'd1, 0, 0, 0); idle(5);
    phase = "R4";  step(1, 2'd2, 0, 0, 0); idle(5);
    phase = "R7";  step(1, 2'd3, 0, 0, 0); step(0, 2'd0, 0, 0, 1);
                   step(1, 2'd3, 0, 0, 1); step(1, 2'd0, 0, 0, 1); idle(5);
    phase = "R5";
    for (int c = 0; c < 3; c++) begin
      for (int i = 0; i < 6; i++) step(1, 2'(c), 0, 0, 0);
      idle(5);
    end
    phase = "R6";  step(1, 2'd2, 0, 0, 0); step(1, 2'd1, 0, 0, 0); step(0, 2'd0, 0, 0, 0);
                   step(1, 2'd0, 0, 0, 1); idle(5);
                   step(1, 2'd0, 0, 0, 0); step(1, 2'd2, 0, 0, 0); step(1, 2'd1, 0, 0, 0); idle(5);
    phase = "R8";  step(1, 2'd2, 0, 0, 0); step(1, 2'd1, 1, 0, 0); step(1, 2'd0, 1, 0, 1);
                   step(1, 2'd3, 1, 0, 0); idle(5);
    phase = "R9";  step(1, 2'd2, 0, 0, 0); step(1, 2'd1, 0, 0, 0); step(1, 2'd0, 0, 0, 1);
                   step(1, 2'd2, 0, 1, 1); idle(5);
    phase = "R10"; idle(8);
    phase = "R6 sweep";
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      step(lfsr[0] | lfsr[5], lfsr[2:1], lfsr[4:3] == 2'b11, lfsr[9:6] == 4'hF, lfsr[10] & lfsr[11]);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end
    idle(6);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule